// File: doc/BRIEF.md
# Register Pair and Stack Unit

This block keeps the six byte-wide general registers of a small 8-bit processor as three 16-bit pairs, together with a 16-bit stack pointer and a 16-bit program counter. It runs the commands that act on whole pairs: increment, decrement, add into HL, swapping DE with HL, and copying HL into SP or PC. It also runs the commands that move pairs through a stack held in byte-wide memory: push, pop, exchange of HL with the stack top, subroutine call and return.

A command is offered with a one-cycle start pulse. Register-only commands finish on that clock edge. Stack commands raise `busy` and step through their memory transfers on a request/acknowledge byte port, one transfer at a time. The accumulator and flag byte come in from outside as the push source of the accumulator pair, and go back out as the result of a pop of that pair. The ALU, the flag logic and instruction fetch are outside this block.

Top module: `rps_unit`

## Requirements
- R1: Each pair is a 16-bit value with the first-named register as the high byte. Pair code: 0 = BC, 1 = DE, 2 = HL, 3 = SP for arithmetic, or the accumulator pair for push and pop. In the accumulator pair the accumulator is the high byte and the flag byte is the low byte.
- R2: Increment (op 1) and decrement (op 2) act on the selected pair or on SP as one 16-bit value that wraps modulo 65536. They never pulse `cy_valid`.
- R3: Add-into-HL (op 3) stores HL plus the selected pair in HL. It drives `cy_out` with the carry out of bit 15 and pulses `cy_valid` for exactly one cycle.
- R4: Op 4 swaps DE with HL. Op 5 copies HL into SP. Op 6 copies HL into PC. Each takes effect on the start edge.
- R5: Push (op 7) writes the high byte to SP-1, then the low byte to SP-2. SP steps down by one after each acknowledged write, and all SP steps wrap modulo 65536.
- R6: Pop (op 8) reads the low byte from SP, then the high byte from SP+1. SP steps up by one after each acknowledged read. A pop of the accumulator pair drives `acc_out` and `flg_out` and pulses `acc_valid`.
- R7: Exchange with the stack top (op 9) reads SP, writes L to SP, reads SP+1, then writes H to SP+1. HL takes the two bytes that were read, and SP does not change.
- R8: Call (op 10) pushes PC in the R5 byte order and then loads PC with `cmd_target`. Return (op 11) pops two bytes into PC, low byte first.
- R9: `busy` is high from the edge after a stack command's start until its last acknowledge. A start pulse while `busy` is high is ignored. A request holds its address, direction and data until it is acknowledged, and no request is raised while the block is idle.
- R10: Reset clears PC, `busy` and `mem_req`. SP is not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command code |
| cmd_pair | input | 2 | Pair select |
| cmd_target | input | 16 | Call destination |
| acc_in | input | 8 | Accumulator value for pushes |
| flg_in | input | 8 | Flag byte for pushes |
| busy | output | 1 | Stack command in progress |
| pair_bc | output | 16 | BC pair |
| pair_de | output | 16 | DE pair |
| pair_hl | output | 16 | HL pair |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |
| cy_out | output | 1 | Carry of the last add into HL |
| cy_valid | output | 1 | One-cycle pulse when cy_out updates |
| acc_out | output | 8 | Accumulator from a pop |
| flg_out | output | 8 | Flag byte from a pop |
| acc_valid | output | 1 | One-cycle pulse when acc_out/flg_out update |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transfer accepted; read data valid |
| mem_rdata | input | 8 | Read data |

## Verification
Two things can land on the same clock edge. One is a new start pulse arriving while a stack command is still waiting for an acknowledge. The other is the final acknowledge of a call, where SP takes its last step and PC takes the target together. The bench provokes the first by pulsing an increment of HL one cycle after a push has started. It judges the result by checking that HL is unchanged and that only the push's two writes appear at the memory port. The second is judged by reading SP and PC together after a call, under acknowledge latencies of zero to two idle cycles.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_INC    = 4'd1,
    OP_DEC    = 4'd2,
    OP_ADDHL  = 4'd3,
    OP_SWAPDH = 4'd4,
    OP_SPHL   = 4'd5,
    OP_PCHL   = 4'd6,
    OP_PUSH   = 4'd7,
    OP_POP    = 4'd8,
    OP_XTOP   = 4'd9,
    OP_CALL   = 4'd10,
    OP_RET    = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_ADD = 2'd2
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/rps_pair_alu.sv
module rps_pair_alu #(
  parameter int WW = 16
) (
  input  rps_pkg::amode_e mode,
  input  logic [WW-1:0]   a,
  input  logic [WW-1:0]   b,
  output logic [WW-1:0]   sum,
  output logic            carry
);
  logic [WW-1:0] opnd;

  always_comb begin
    case (mode)
      rps_pkg::AM_INC: opnd = WW'(1);
      rps_pkg::AM_DEC: opnd = '1;
      default:         opnd = b;
    endcase
    {carry, sum} = {1'b0, a} + {1'b0, opnd};
  end
endmodule

// File: rtl/rps_req_reg.sv
module rps_req_reg #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clear,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] data_i,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      addr <= '0;
      we   <= 1'b0;
      data <= '0;
    end else if (load) begin
      req  <= 1'b1;
      addr <= addr_i;
      we   <= we_i;
      data <= data_i;
    end else if (clear) begin
      req  <= 1'b0;
    end
  end
endmodule

// File: rtl/rps_unit.sv
module rps_unit #(
  parameter int DW = 8,
  parameter int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic [3:0]    cmd_op,
  input  logic [1:0]    cmd_pair,
  input  logic [WW-1:0] cmd_target,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] flg_in,
  output logic          busy,
  output logic [WW-1:0] pair_bc,
  output logic [WW-1:0] pair_de,
  output logic [WW-1:0] pair_hl,
  output logic [WW-1:0] sp_out,
  output logic [WW-1:0] pc_out,
  output logic          cy_out,
  output logic          cy_valid,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] flg_out,
  output logic          acc_valid,
  output logic          mem_req,
  output logic          mem_we,
  output logic [WW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import rps_pkg::*;

  localparam logic [1:0] PR_BC = 2'd0;
  localparam logic [1:0] PR_DE = 2'd1;
  localparam logic [1:0] PR_HL = 2'd2;
  localparam logic [1:0] PR_X  = 2'd3;

  logic [WW-1:0] bc_q, de_q, hl_q, sp_q, pc_q;
  logic [WW-1:0] word_q, tgt_q;
  logic [DW-1:0] tmp_q;
  logic [1:0]    pair_q, step_q;
  op_e           op_q, cmd_e;
  st_e           st_q;

  // selected pair for register commands
  logic [WW-1:0] sel_word;
  always_comb begin
    case (cmd_pair)
      PR_BC:   sel_word = bc_q;
      PR_DE:   sel_word = de_q;
      PR_HL:   sel_word = hl_q;
      default: sel_word = sp_q;
    endcase
  end

  assign cmd_e = op_e'(cmd_op);

  amode_e        amode;
  logic [WW-1:0] alu_sum;
  logic          alu_cy;
  assign amode = (cmd_e == OP_INC) ? AM_INC : (cmd_e == OP_DEC) ? AM_DEC : AM_ADD;

  rps_pair_alu #(.WW(WW)) u_alu (
    .mode  (amode),
    .a     ((cmd_e == OP_ADDHL) ? hl_q : sel_word),
    .b     (sel_word),
    .sum   (alu_sum),
    .carry (alu_cy)
  );

  // request contents for the current step
  logic          push_like, pop_like, last_step;
  logic [WW-1:0] rq_addr;
  logic          rq_we;
  logic [DW-1:0] rq_data;

  assign push_like = (op_q == OP_PUSH) || (op_q == OP_CALL);
  assign pop_like  = (op_q == OP_POP)  || (op_q == OP_RET);
  assign last_step = (op_q == OP_XTOP) ? (step_q == 2'd3) : (step_q == 2'd1);

  always_comb begin
    rq_addr = sp_q;
    rq_we   = 1'b0;
    rq_data = '0;
    if (push_like) begin
      rq_addr = sp_q - 1'b1;
      rq_we   = 1'b1;
      rq_data = (step_q == 2'd0) ? word_q[WW-1:DW] : word_q[DW-1:0];
    end else if (op_q == OP_XTOP) begin
      rq_addr = step_q[1] ? WW'(sp_q + 1'b1) : sp_q;
      rq_we   = step_q[0];
      rq_data = step_q[1] ? hl_q[WW-1:DW] : hl_q[DW-1:0];
    end
  end

  rps_req_reg #(.AW(WW), .DW(DW)) u_req (
    .clk    (clk),
    .rst    (rst),
    .load   (st_q == ST_ISSUE),
    .clear  ((st_q == ST_WAIT) && mem_ack),
    .addr_i (rq_addr),
    .we_i   (rq_we),
    .data_i (rq_data),
    .req    (mem_req),
    .addr   (mem_addr),
    .we     (mem_we),
    .data   (mem_wdata)
  );

  // SP is intentionally left out of the reset branch
  always_ff @(posedge clk) begin
    cy_valid  <= 1'b0;
    acc_valid <= 1'b0;
    if (rst) begin
      st_q    <= ST_IDLE;
      busy    <= 1'b0;
      bc_q    <= '0;
      de_q    <= '0;
      hl_q    <= '0;
      pc_q    <= '0;
      cy_out  <= 1'b0;
      acc_out <= '0;
      flg_out <= '0;
      op_q    <= OP_NOP;
      pair_q  <= '0;
      step_q  <= '0;
      word_q  <= '0;
      tgt_q   <= '0;
      tmp_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_start) begin
          case (cmd_e)
            OP_INC, OP_DEC: begin
              case (cmd_pair)
                PR_BC:   bc_q <= alu_sum;
                PR_DE:   de_q <= alu_sum;
                PR_HL:   hl_q <= alu_sum;
                default: sp_q <= alu_sum;
              endcase
            end
            OP_ADDHL: begin
              hl_q     <= alu_sum;
              cy_out   <= alu_cy;
              cy_valid <= 1'b1;
            end
            OP_SWAPDH: begin
              de_q <= hl_q;
              hl_q <= de_q;
            end
            OP_SPHL: sp_q <= hl_q;
            OP_PCHL: pc_q <= hl_q;
            OP_PUSH, OP_POP, OP_XTOP, OP_CALL, OP_RET: begin
              op_q   <= cmd_e;
              pair_q <= cmd_pair;
              tgt_q  <= cmd_target;
              step_q <= '0;
              busy   <= 1'b1;
              st_q   <= ST_ISSUE;
              if (cmd_e == OP_CALL)     word_q <= pc_q;
              else if (cmd_pair == PR_X) word_q <= {acc_in, flg_in};
              else                       word_q <= sel_word;
            end
            default: ;
          endcase
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (mem_ack) begin
          if (push_like) begin
            sp_q <= sp_q - 1'b1;
            if (last_step && op_q == OP_CALL) pc_q <= tgt_q;
          end else if (pop_like) begin
            sp_q <= sp_q + 1'b1;
            if (!last_step) word_q[DW-1:0] <= mem_rdata;
            else if (op_q == OP_RET) pc_q <= {mem_rdata, word_q[DW-1:0]};
            else begin
              case (pair_q)
                PR_BC: bc_q <= {mem_rdata, word_q[DW-1:0]};
                PR_DE: de_q <= {mem_rdata, word_q[DW-1:0]};
                PR_HL: hl_q <= {mem_rdata, word_q[DW-1:0]};
                default: begin
                  acc_out   <= mem_rdata;
                  flg_out   <= word_q[DW-1:0];
                  acc_valid <= 1'b1;
                end
              endcase
            end
          end else begin
            case (step_q)
              2'd0, 2'd2: tmp_q <= mem_rdata;
              2'd1:       hl_q[DW-1:0]  <= tmp_q;
              default:    hl_q[WW-1:DW] <= tmp_q;
            endcase
          end
          if (last_step) begin
            busy <= 1'b0;
            st_q <= ST_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pair_bc = bc_q;
  assign pair_de = de_q;
  assign pair_hl = hl_q;
  assign sp_out  = sp_q;
  assign pc_out  = pc_q;
endmodule

// File: rtl/rps_unit_chk.sv
module rps_unit_chk #(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [WW-1:0] mem_addr,
  input logic [WW-1:0] sp_q,
  input logic [WW-1:0] pc_q,
  input rps_pkg::op_e  op_q
);
  import rps_pkg::*;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R9

  AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && mem_we && op_q != OP_XTOP |=> sp_q == WW'($past(sp_q) - 1'b1)); // R5

  AST_POP_SP_UP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !mem_we && op_q != OP_XTOP |=> sp_q == WW'($past(sp_q) + 1'b1)); // R6

  AST_XTOP_SP_FIXED: assert property (@(posedge clk) disable iff (rst)
    mem_req && op_q == OP_XTOP |=> $stable(sp_q)); // R7

  AST_XTOP_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_req && op_q == OP_XTOP |-> (mem_addr == sp_q) || (mem_addr == WW'(sp_q + 1'b1))); // R7

  AST_PC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc_q == '0 && !busy); // R10
endmodule

bind rps_unit rps_unit_chk #(.WW(WW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .sp_q     (sp_q),
  .pc_q     (pc_q),
  .op_q     (op_q)
);

// File: tb/tb_rps_unit.sv
module tb_rps_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [1:0]  cmd_pair = 2'd0;
  logic [15:0] cmd_target = 16'h0;
  logic [7:0]  acc_in = 8'h0, flg_in = 8'h0;
  logic        busy, cy_out, cy_valid, acc_valid;
  logic [15:0] pair_bc, pair_de, pair_hl, sp_out, pc_out;
  logic [7:0]  acc_out, flg_out;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h0;

  rps_unit dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0, ntx = 0, lat = 0;
  logic [7:0] mem [256];

  // scoreboard of expected memory transfers
  logic [24:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic expect_tx(input logic we, input logic [15:0] a, input logic [7:0] d, input string r);
    exp_q.push_back({we, a, d});
    tag_q.push_back(r);
  endtask

  // memory responder and monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat < ntx % 3) lat++;
      else begin
        lat = 0;
        ntx++;
        if (exp_q.size() == 0) begin
          chk("R9 unexpected transfer", {7'd0, mem_we, mem_addr, mem_wdata}, 32'h0);
        end else begin
          logic [24:0] e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          chk(r, {7'd0, mem_we, mem_addr, (mem_we ? mem_wdata : 8'h0)},
                 {7'd0, e[24], e[23:8], (e[24] ? e[7:0] : 8'h0)});
        end
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else mem_rdata = mem[mem_addr[7:0]];
        mem_ack = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input logic [3:0] op, input logic [1:0] pr, input logic [15:0] tgt);
    @(negedge clk);
    cmd_op = op; cmd_pair = pr; cmd_target = tgt; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h34; mem[1] = 8'h12;
    mem[2] = 8'hCD; mem[3] = 8'hAB;
    mem[4] = 8'hFF; mem[5] = 8'hFF;
    mem[6] = 8'h11; mem[7] = 8'h22;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 pc", pc_out, 0);
    chk("R10 busy", busy, 0);
    chk("R10 mem_req", mem_req, 0);

    run(4'd5, 2'd0, 0);                       // SP <- HL (0)
    chk("R4 sp from hl", sp_out, 16'h0000);

    expect_tx(1, 16'hFFFF, 8'h00, "R5 push wrap hi");
    expect_tx(1, 16'hFFFE, 8'h00, "R5 push wrap lo");
    run(4'd7, 2'd0, 0);
    chk("R5 sp after wrap push", sp_out, 16'hFFFE);
    run(4'd1, 2'd3, 0);
    run(4'd1, 2'd3, 0);
    chk("R2 sp inc wrap", sp_out, 16'h0000);

    expect_tx(0, 16'h0000, 0, "R6 pop lo");
    expect_tx(0, 16'h0001, 0, "R6 pop hi");
    run(4'd8, 2'd2, 0);
    chk("R1 hl byte order", pair_hl, 16'h1234);
    chk("R6 sp after pop", sp_out, 16'h0002);
    expect_tx(0, 16'h0002, 0, "R6 pop de lo");
    expect_tx(0, 16'h0003, 0, "R6 pop de hi");
    run(4'd8, 2'd1, 0);
    chk("R1 de", pair_de, 16'hABCD);
    expect_tx(0, 16'h0004, 0, "R6 pop bc lo");
    expect_tx(0, 16'h0005, 0, "R6 pop bc hi");
    run(4'd8, 2'd0, 0);
    chk("R1 bc", pair_bc, 16'hFFFF);

    run(4'd1, 2'd0, 0);
    chk("R2 inc wrap", pair_bc, 16'h0000);
    chk("R2 no carry pulse", cy_valid, 0);
    run(4'd2, 2'd0, 0);
    chk("R2 dec wrap", pair_bc, 16'hFFFF);
    run(4'd2, 2'd3, 0);
    chk("R2 dec sp", sp_out, 16'h0005);
    run(4'd1, 2'd3, 0);

    run(4'd3, 2'd1, 0);
    chk("R3 add de", pair_hl, 16'hBE01);
    chk("R3 cy clear", cy_out, 0);
    chk("R3 cy pulse", cy_valid, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", cy_valid, 0);
    run(4'd3, 2'd0, 0);
    chk("R3 add bc", pair_hl, 16'hBE00);
    chk("R3 cy set", cy_out, 1);
    run(4'd3, 2'd2, 0);
    chk("R3 add hl", pair_hl, 16'h7C00);
    chk("R3 cy double", cy_out, 1);

    run(4'd4, 2'd0, 0);
    chk("R4 swap de", pair_de, 16'h7C00);
    chk("R4 swap hl", pair_hl, 16'hABCD);

    expect_tx(1, 16'h0005, 8'h7C, "R5 push hi");
    expect_tx(1, 16'h0004, 8'h00, "R5 push lo");
    run(4'd7, 2'd1, 0);
    chk("R5 sp", sp_out, 16'h0004);

    acc_in = 8'h5A; flg_in = 8'hC3;
    expect_tx(1, 16'h0003, 8'h5A, "R5 push acc hi");
    expect_tx(1, 16'h0002, 8'hC3, "R5 push flags lo");
    run(4'd7, 2'd3, 0);
    acc_in = 8'h00; flg_in = 8'h00;
    expect_tx(0, 16'h0002, 0, "R6 pop flags");
    expect_tx(0, 16'h0003, 0, "R6 pop acc");
    run(4'd8, 2'd3, 0);
    chk("R6 acc_valid", acc_valid, 1);
    chk("R6 acc", acc_out, 8'h5A);
    chk("R6 flags", flg_out, 8'hC3);
    expect_tx(0, 16'h0004, 0, "R6 pop bc lo");
    expect_tx(0, 16'h0005, 0, "R6 pop bc hi");
    run(4'd8, 2'd0, 0);
    chk("R6 bc", pair_bc, 16'h7C00);
    chk("R6 sp", sp_out, 16'h0006);

    expect_tx(0, 16'h0006, 0,     "R7 read top");
    expect_tx(1, 16'h0006, 8'hCD, "R7 write L");
    expect_tx(0, 16'h0007, 0,     "R7 read next");
    expect_tx(1, 16'h0007, 8'hAB, "R7 write H");
    run(4'd9, 2'd0, 0);
    chk("R7 hl", pair_hl, 16'h2211);
    chk("R7 sp unchanged", sp_out, 16'h0006);
    chk("R7 mem", {mem[7], mem[6]}, 16'hABCD);

    run(4'd6, 2'd0, 0);
    chk("R4 pc from hl", pc_out, 16'h2211);

    expect_tx(1, 16'h0005, 8'h22, "R8 call hi");
    expect_tx(1, 16'h0004, 8'h11, "R8 call lo");
    run(4'd10, 2'd0, 16'h0400);
    chk("R8 call pc", pc_out, 16'h0400);
    chk("R8 call sp", sp_out, 16'h0004);
    expect_tx(0, 16'h0004, 0, "R8 ret lo");
    expect_tx(0, 16'h0005, 0, "R8 ret hi");
    run(4'd11, 2'd0, 0);
    chk("R8 ret pc", pc_out, 16'h2211);
    chk("R8 ret sp", sp_out, 16'h0006);

    // start pulse during busy must be ignored
    expect_tx(1, 16'h0005, 8'h7C, "R9 push hi");
    expect_tx(1, 16'h0004, 8'h00, "R9 push lo");
    @(negedge clk);
    cmd_op = 4'd7; cmd_pair = 2'd0; cmd_start = 1'b1;
    @(negedge clk);
    chk("R9 busy raised", busy, 1);
    cmd_op = 4'd1; cmd_pair = 2'd2;
    @(negedge clk);
    cmd_start = 1'b0;
    while (busy) @(negedge clk);
    chk("R9 hl untouched", pair_hl, 16'h2211);
    chk("R9 sp", sp_out, 16'h0004);
    repeat (4) @(negedge clk);
    chk("R9 idle no req", mem_req, 0);
    chk("R9 queue drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule